// File: doc/BRIEF.md
# Fixed-OR Programmable Array Logic

This block models a sum-of-products logic device in which only the AND plane can be configured. Every product term sees every input, in both its true and its inverted form. A small fuse row per term chooses which of those literals take part. The OR plane is set when the block is elaborated. Each output owns a contiguous, fixed-size group of product terms and ORs only that group, so no term is ever shared between outputs.

A host loads the fuse map one product term per clock through a write port. The host addresses each term by its global index. Evaluation is purely combinational from the data inputs and the stored fuses. Before loading, each function has to be minimised so that it fits the term budget of its output. With the default parameters there are four inputs and three outputs. The first two outputs own three terms each and the third owns two, which gives eight terms in total.

Top module: `pal_fixed_or`

## Requirements
- R1: While reset is asserted, and after it is released, every fuse pair holds code 11, so every output reads 0 for every input until a term is written.
- R2: In a fuse row, bits [2i+1:2i] control input i. Bit 2i+1 connects the true literal and bit 2i connects the inverted literal: 10 uses the input, 01 uses its inverse, 00 leaves it out, and 11 forces the whole term to 0.
- R3: A row whose pairs are all 00 makes a term that is constantly 1, and its owning output then reads 1 for every input.
- R4: On a rising clock edge with `cfg_we` high and `cfg_term` below the term count, the whole row of that term is replaced in that one cycle. The outputs reflect the new row right after that edge and not before it.
- R5: Global term indices are allocated in order of output: terms 0..2 feed `dout[0]`, terms 3..5 feed `dout[1]`, and terms 6..7 feed `dout[2]`. Each output is the OR of its own group's terms.
- R6: Changing a term never changes any output other than the one that owns it.
- R7: A write whose `cfg_term` is equal to or above the term count (8) is ignored, and every output stays as it was.
- R8: A write to one term leaves the rows of all other terms unchanged.
- R9: The outputs follow `din` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for fuse writes |
| rst_n | input | 1 | Asynchronous active-low reset, sets all fuses to 11 |
| cfg_we | input | 1 | Fuse row write enable |
| cfg_term | input | 4 | Global product-term index to write |
| cfg_fuses | input | 8 | New fuse row, two bits per input |
| din | input | 4 | Logic inputs (bit 0 = a, bit 3 = d) |
| dout | output | 3 | Sum-of-products outputs |

## Verification
The bench loads minimal covers for three functions and compares all sixteen input combinations against boolean expressions, so a misordered fuse pair or a wrong term-to-output boundary shows up as wrong minterms on one output. A row of all-open fuses on the last term must drive only the third output high; a design that shared terms, or that put the group boundary off by one, would disturb the other outputs. A write to an index past the last term must leave the outputs dark, which catches a decoder that wraps the index. Overwriting one term with a kill row must drop exactly that term's minterms, and a sample taken before the write edge must still show the old value.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam logic [1:0] FC_OPEN = 2'b00;
  localparam logic [1:0] FC_INV  = 2'b01;
  localparam logic [1:0] FC_TRUE = 2'b10;
  localparam logic [1:0] FC_KILL = 2'b11;

  // Contribution of one input literal to a product term.
  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    logic r;
    case (code)
      FC_OPEN: r = 1'b1;
      FC_INV:  r = ~x;
      FC_TRUE: r = x;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
  parameter int N_TERMS = 8,
  parameter int FUSE_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [FUSE_W-1:0]           wdata,
  output logic [N_TERMS*FUSE_W-1:0]   fuse_map,
  output logic [N_TERMS-1:0]          hit_vec
);

  for (genvar t = 0; t < N_TERMS; t++) begin : g_row
    logic [FUSE_W-1:0] row_q;
    logic              sel;
    assign sel = we && (idx == IDX_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row_q <= '1;
      else if (sel) row_q <= wdata;
    end
    assign fuse_map[t*FUSE_W +: FUSE_W] = row_q;
    assign hit_vec[t] = sel;
  end

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
  import pal_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS*2*N_IN-1:0] fuse_map,
  input  logic [N_IN-1:0]           din,
  output logic [N_TERMS-1:0]        term_vec
);

  localparam int FUSE_W = 2 * N_IN;

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [FUSE_W-1:0] row;
    logic              prod;
    assign row = fuse_map[t*FUSE_W +: FUSE_W];
    always_comb begin
      prod = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        prod = prod & lit_pass(row[2*i +: 2], din[i]);
      end
    end
    assign term_vec[t] = prod;
  end

endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
  parameter int N_OUT          = 3,
  parameter int TERMS [N_OUT]  = '{3, 3, 2},
  parameter int N_TERMS        = 8
) (
  input  logic [N_TERMS-1:0] term_vec,
  output logic [N_OUT-1:0]   dout
);

  function automatic int base_of(input int o);
    int s;
    s = 0;
    for (int k = 0; k < o; k++) s += TERMS[k];
    return s;
  endfunction

  function automatic logic [N_TERMS-1:0] group_mask(input int base, input int cnt);
    logic [N_TERMS-1:0] m;
    m = '0;
    for (int k = 0; k < N_TERMS; k++) begin
      if (k >= base && k < base + cnt) m[k] = 1'b1;
    end
    return m;
  endfunction

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int                 BASE = base_of(o);
    localparam logic [N_TERMS-1:0] MASK = group_mask(BASE, TERMS[o]);
    assign dout[o] = |(term_vec & MASK);
  end

endmodule

// File: rtl/pal_fixed_or.sv
module pal_fixed_or #(
  parameter int N_IN          = 4,
  parameter int N_OUT         = 3,
  parameter int TERMS [N_OUT] = '{3, 3, 2}
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [$clog2(TERMS[0]+TERMS[1]+TERMS[2]+1)-1:0] cfg_term,
  input  logic [2*N_IN-1:0]                      cfg_fuses,
  input  logic [N_IN-1:0]                        din,
  output logic [N_OUT-1:0]                       dout
);

  function automatic int total_terms();
    int s;
    s = 0;
    for (int k = 0; k < N_OUT; k++) s += TERMS[k];
    return s;
  endfunction

  localparam int P      = total_terms();
  localparam int FUSE_W = 2 * N_IN;
  localparam int IDX_W  = $bits(cfg_term);

  logic [P*FUSE_W-1:0] fuse_map;
  logic [P-1:0]        hit_vec;
  logic [P-1:0]        term_vec;

  pal_fuse_store #(.N_TERMS(P), .FUSE_W(FUSE_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_term), .wdata(cfg_fuses),
    .fuse_map(fuse_map), .hit_vec(hit_vec)
  );

  pal_and_plane #(.N_IN(N_IN), .N_TERMS(P)) u_and (
    .fuse_map(fuse_map), .din(din), .term_vec(term_vec)
  );

  pal_or_plane #(.N_OUT(N_OUT), .TERMS(TERMS), .N_TERMS(P)) u_or (
    .term_vec(term_vec), .dout(dout)
  );

endmodule

// File: rtl/pal_fixed_or_chk.sv
module pal_fixed_or_chk #(
  parameter int N_IN          = 4,
  parameter int N_OUT         = 3,
  parameter int TERMS [N_OUT] = '{3, 3, 2},
  parameter int P             = 8,
  parameter int IDX_W         = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [IDX_W-1:0]       cfg_term,
  input logic [2*N_IN-1:0]      cfg_fuses,
  input logic [N_OUT-1:0]       dout,
  input logic [P-1:0]           term_vec,
  input logic [P-1:0]           hit_vec,
  input logic [P*2*N_IN-1:0]    fuse_map
);

  function automatic int owner_of(input int t);
    int s;
    int r;
    s = 0;
    r = 0;
    for (int k = 0; k < N_OUT; k++) begin
      if (t >= s && t < s + TERMS[k]) r = k;
      s += TERMS[k];
    end
    return r;
  endfunction

  for (genvar t = 0; t < P; t++) begin : g_t
    localparam int OWN = owner_of(t);
    AST_KILL_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_term == IDX_W'(t) && cfg_fuses == '1) |=> !term_vec[t]); // R2
    AST_OPEN_ROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_term == IDX_W'(t) && cfg_fuses == '0) |=> (term_vec[t] && dout[OWN])); // R3
  end

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || cfg_term >= IDX_W'(P)) |=> $stable(fuse_map)); // R7
  AST_OUT_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (|dout) |-> (|term_vec)); // R5
  AST_ONE_ROW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8

endmodule

bind pal_fixed_or pal_fixed_or_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .TERMS(TERMS), .P(P), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_term(cfg_term),
  .cfg_fuses(cfg_fuses), .dout(dout), .term_vec(term_vec),
  .hit_vec(hit_vec), .fuse_map(fuse_map)
);

// File: tb/sim_pal_fixed_or.sv
`timescale 1ns/1ps
module sim_pal_fixed_or;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_term = '0;
  logic [7:0] cfg_fuses = '0;
  logic [3:0] din = '0;
  logic [2:0] dout;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pal_fixed_or u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_term(cfg_term),
    .cfg_fuses(cfg_fuses), .din(din), .dout(dout)
  );

  // Minimal covers, row format per R2: pair i = {true, inverse}.
  localparam logic [11:0] LOADS [8] = '{
    {4'd0, 8'b00_00_01_10},   // a & ~b
    {4'd1, 8'b10_10_00_00},   // c & d
    {4'd2, 8'b00_01_00_01},   // ~a & ~c
    {4'd3, 8'b00_00_10_01},   // ~a & b
    {4'd4, 8'b10_01_10_00},   // b & ~c & d
    {4'd5, 8'b01_00_00_10},   // a & ~d
    {4'd6, 8'b00_00_10_10},   // a & b
    {4'd7, 8'b10_01_00_00}    // ~c & d
  };

  function automatic logic [2:0] model(input logic [3:0] v, input int variant);
    logic a, b, c, d, f0, f1, f2;
    {d, c, b, a} = v;
    f0 = (a && !b) || (c && d) || (!a && !c);
    f1 = (!a && b) || (b && !c && d) || (a && !d);
    f2 = (a && b) || (!c && d);
    if (variant == 1) f2 = 1'b1;
    if (variant == 2) f0 = (c && d) || (!a && !c);
    return {f2, f1, f0};
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s din=%b got=%b expected=%b", req, din, got, exp);
    end
  endtask

  task automatic write_row(input logic [3:0] idx, input logic [7:0] f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = idx; cfg_fuses = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sweep(input string req, input int variant, input bit all_zero);
    for (int v = 0; v < 16; v++) begin
      din = 4'(v);
      #1;
      check(req, dout, all_zero ? 3'b000 : model(4'(v), variant));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    sweep("R1 in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 after reset", 0, 1);

    // R7: index past the last term is ignored
    write_row(4'd9, 8'h00);
    sweep("R7 out-of-range write", 0, 1);

    // R4: new row visible only after the write edge
    din = 4'b0011;
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = 4'd6; cfg_fuses = LOADS[6][7:0];
    #1;
    check("R4 before edge", dout, 3'b000);
    @(posedge clk);
    #1;
    check("R4 after edge", dout, 3'b100);
    @(negedge clk);
    cfg_we = 1'b0;

    for (int k = 0; k < 8; k++) write_row(LOADS[k][11:8], LOADS[k][7:0]);
    sweep("R5 R2 full cover", 0, 0);

    // R9: output follows din with no clock edge in between
    @(posedge clk);
    #2;
    din = 4'b1000;
    #1;
    check("R9 comb step", dout, model(4'b1000, 0));
    din = 4'b0101;
    #1;
    check("R9 comb step", dout, model(4'b0101, 0));

    // R3 and R6: all-open last term drives only its own output
    write_row(4'd7, 8'h00);
    sweep("R3 R6 open term", 1, 0);
    write_row(4'd7, LOADS[7][7:0]);
    sweep("R6 restore", 0, 0);

    // R8 and R2 kill code: one term removed, others intact
    write_row(4'd0, 8'hFF);
    sweep("R8 R2 kill row", 2, 0);

    // R1: reset asserted mid-run clears the map
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    sweep("R1 reset mid-run", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    din = 4'b1111;
    #1;
    check("R1 after re-release", dout, 3'b000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule